// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. The burst length, the beat ordering and the single-write option come from a programmed mode word. A controller starts a burst by pulsing a command strobe along with the start column and a read/write flag. From the next cycle the block presents one column per clock, with a valid flag. A last-beat flag marks the final beat of any burst of fixed length.

Bursts of 1, 2, 4 or 8 beats stay inside an aligned block of columns. They follow either a wrapping upward count or an XOR pattern. Full-page bursts step through the whole 512-column row, wrap from the top column to zero, and keep running until something ends them. A new command can take over a running burst on any cycle, and so can a stop pulse. A mode word with a reserved code is reported as an error, and in that case no burst is issued.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After the synchronous active-high reset, beat_valid, beat_last and mode_err are all 0.
- R2: Mode bits [2:0] = 000, 001, 010 or 011 give bursts of 1, 2, 4 or 8 beats. beat_last is 1 only on the final beat. beat_valid falls in the cycle after that beat. beat_last is never 1 while beat_valid is 0.
- R3: When mode bit 3 is 0 (sequential), beat k of a burst of length L has its low log2(L) bits equal to (start + k) mod L, and its upper bits equal to those of the start column.
- R4: When mode bit 3 is 1 (interleave), beat k of a fixed-length burst is the start column XOR k.
- R5: Mode bits [2:0] = 111 with bit 3 = 0 select full page. The column rises by one each beat, wraps from 511 to 0, and continues with beat_last held at 0 until a stop or a new command.
- R6: A command issued under a reserved mode is rejected. Reserved modes are lengths 100, 101 and 110, and length 111 together with bit 3 = 1. The rejection raises mode_err for exactly one cycle, drives beat_valid to 0, and ends any running burst.
- R7: With mode bit 9 = 1, a write command produces one beat with beat_last set. A read command keeps the programmed length.
- R8: A command taken while a burst is running replaces it. In the next cycle beat_col equals the new start column and the beat count restarts.
- R9: cmd_stop ends the burst, so beat_valid is 0 in the following cycle. When cmd_go and cmd_stop arrive together, the command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_word | input | MODE_W (12) | Programmed mode word, decoded when a command is taken |
| cmd_go | input | 1 | Read or write command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read, sampled with cmd_go |
| cmd_col | input | COL_W (9) | Start column, sampled with cmd_go |
| cmd_stop | input | 1 | Burst-stop pulse |
| beat_col | output | COL_W (9) | Column of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Current beat is the final one of a fixed-length burst |
| mode_err | output | 1 | One-cycle pulse: a command was rejected for a reserved mode |

## Verification
A corrupted beat index or base register shows up on beat_col on the very next beat. In sequential mode the fault appears as a wrong low-bit wrap or as changed upper bits. In interleave mode it breaks the XOR pattern. A fault in the latched length shows as beat_last on the wrong beat, or as valid lasting one beat too long or too short. Both are seen within at most eight cycles of the command. Full-page wrap faults show up at the 511-to-0 crossing, and faults in command priority show up one cycle after a stop or interrupt.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Field positions inside the mode word (the decoder depends on these)
  localparam int LEN_LSB     = 0;
  localparam int LEN_W       = 3;
  localparam int ORDER_BIT   = 3;
  localparam int WSINGLE_BIT = 9;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef struct packed {
    logic       err;   // reserved encoding
    logic       full;  // unbounded full-page burst
    logic [1:0] lg;    // log2 of fixed burst length
    order_e     ord;   // beat ordering
  } burst_cfg_t;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic [MODE_W-1:0] mode_word,
  input  logic              is_write,
  output burst_cfg_t        cfg
);

  logic [LEN_W-1:0] len_code;
  assign len_code = mode_word[LEN_LSB +: LEN_W];

  always_comb begin
    cfg     = '0;
    cfg.ord = order_e'(mode_word[ORDER_BIT]);
    case (len_code)
      3'b000, 3'b001, 3'b010, 3'b011: cfg.lg = len_code[1:0];
      3'b111: begin
        if (cfg.ord == ORD_ILV) cfg.err  = 1'b1;
        else                    cfg.full = 1'b1;
      end
      default: cfg.err = 1'b1;
    endcase
    // single-beat writes override the programmed length
    if (is_write && mode_word[WSINGLE_BIT] && !cfg.err) begin
      cfg.full = 1'b0;
      cfg.lg   = 2'd0;
    end
  end

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [1:0]       lg,
  input  logic             full,
  input  order_e           ord,
  output logic [COL_W-1:0] col,
  output logic [COL_W-1:0] wrap_mask
);

  logic [COL_W-1:0] sum;

  // bit b of the wrap mask is set when it lies inside the burst block
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign wrap_mask[b] = full | (32'(lg) > b);
  end

  assign sum = base + idx;

  always_comb begin
    if (ord == ORD_ILV) col = base ^ idx;
    else                col = (base & ~wrap_mask) | (sum & wrap_mask);
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_go,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_stop,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_valid,
  output logic              beat_last,
  output logic              mode_err
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  burst_cfg_t       dec_cfg;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] nxt_idx;
  logic [COL_W-1:0] col_nxt;
  logic [COL_W-1:0] mask_q;

  colgen_mode_dec #(.MODE_W(MODE_W)) u_dec (
    .mode_word (mode_word),
    .is_write  (cmd_write),
    .cfg       (dec_cfg)
  );

  assign nxt_idx = idx_q + ONE;

  colgen_addr_calc #(.COL_W(COL_W)) u_calc (
    .base      (base_q),
    .idx       (nxt_idx),
    .lg        (cfg_q.lg),
    .full      (cfg_q.full),
    .ord       (cfg_q.ord),
    .col       (col_nxt),
    .wrap_mask (mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      base_q     <= '0;
      idx_q      <= '0;
      beat_col   <= '0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      mode_err   <= 1'b0;
    end else begin
      mode_err <= 1'b0;
      if (cmd_go) begin
        if (dec_cfg.err) begin
          beat_valid <= 1'b0;
          beat_last  <= 1'b0;
          mode_err   <= 1'b1;
        end else begin
          cfg_q      <= dec_cfg;
          base_q     <= cmd_col;
          idx_q      <= '0;
          beat_col   <= cmd_col;
          beat_valid <= 1'b1;
          beat_last  <= !dec_cfg.full && (dec_cfg.lg == 2'd0);
        end
      end else if (cmd_stop) begin
        beat_valid <= 1'b0;
        beat_last  <= 1'b0;
      end else if (beat_valid) begin
        if (beat_last) begin
          beat_valid <= 1'b0;
          beat_last  <= 1'b0;
        end else begin
          idx_q     <= nxt_idx;
          beat_col  <= col_nxt;
          beat_last <= !cfg_q.full && (nxt_idx == mask_q);
        end
      end
    end
  end

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid); // R2

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    beat_last && !cmd_go |=> !beat_valid); // R2

  AST_SEQ_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_last && cfg_q.ord == ORD_SEQ && !cmd_go && !cmd_stop
    |=> (beat_col & ~mask_q) == ($past(beat_col) & ~$past(mask_q))); // R3

  AST_FULL_STEP: assert property (@(posedge clk) disable iff (rst)
    beat_valid && cfg_q.full && !cmd_go && !cmd_stop
    |=> beat_valid && beat_col == $past(beat_col) + ONE); // R5

  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (rst)
    beat_valid && cfg_q.full |-> !beat_last); // R5

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !beat_valid); // R6

  AST_GO_LOADS: assert property (@(posedge clk) disable iff (rst)
    cmd_go && !dec_cfg.err |=> beat_valid && beat_col == $past(cmd_col)); // R8

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd_stop && !cmd_go |=> !beat_valid); // R9

endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mode_word = '0;
  logic        cmd_go = 1'b0;
  logic        cmd_write = 1'b0;
  logic [8:0]  cmd_col = '0;
  logic        cmd_stop = 1'b0;
  logic [8:0]  beat_col;
  logic        beat_valid;
  logic        beat_last;
  logic        mode_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int         tgt;
    logic       v;
    logic [8:0] c;
    logic       l;
    logic       e;
    string      tag;
  } exp_t;

  exp_t q[$];

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst(rst), .mode_word(mode_word), .cmd_go(cmd_go),
    .cmd_write(cmd_write), .cmd_col(cmd_col), .cmd_stop(cmd_stop),
    .beat_col(beat_col), .beat_valid(beat_valid), .beat_last(beat_last),
    .mode_err(mode_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // mode word: length code [2:0], order bit 3, single-write bit 9
  function automatic logic [11:0] mk(input logic [2:0] code, input logic il, input logic ws);
    logic [11:0] m;
    m = '0;
    m[2:0] = code;
    m[3] = il;
    m[9] = ws;
    return m;
  endfunction

  // expected column for beat i; blen 0 means full page
  function automatic logic [8:0] ecol(input logic [8:0] b, input int i, input int blen, input logic il);
    logic [8:0] m;
    logic [8:0] k;
    k = i[8:0];
    if (blen == 0) return b + k;
    m = 9'(blen - 1);
    if (il) return b ^ k;
    return (b & ~m) | ((b + k) & m);
  endfunction

  task automatic step(input logic [11:0] mw, input logic g, input logic w, input logic [8:0] c,
                      input logic s, input logic ev, input logic [8:0] ec, input logic el,
                      input logic ee, input string tag);
    exp_t it;
    @(posedge clk); #1;
    mode_word = mw; cmd_go = g; cmd_write = w; cmd_col = c; cmd_stop = s;
    it.tgt = cyc + 1; it.v = ev; it.c = ec; it.l = el; it.e = ee; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(mode_word, 0, 0, 9'd0, 0, 0, 9'd0, 0, 0, tag);
  endtask

  task automatic burst(input logic [11:0] mw, input logic w, input logic [8:0] c,
                       input int blen, input logic il, input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(mw, i == 0, w, c, 0, 1, ecol(c, i, blen, il), (blen != 0) && (i == blen - 1), 0, tag);
  endtask

  // monitor: compare each expected item in the cycle it targets
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].tgt == cyc) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (beat_valid !== it.v || beat_last !== it.l || mode_err !== it.e ||
            (it.v && beat_col !== it.c)) begin
          errors++;
          $display("FAIL %s cyc %0d: valid/col/last/err got %b/%h/%b/%b expected %b/%h/%b/%b",
                   it.tag, cyc, beat_valid, beat_col, beat_last, mode_err,
                   it.v, it.c, it.l, it.e);
        end
      end
    end
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle("R1 reset state");
    idle("R1 reset state");

    // R2 / R3 sequential lengths
    burst(mk(3'b000, 0, 0), 0, 9'h010, 1, 0, 1, "R2 len1");
    idle("R2 end len1");
    burst(mk(3'b001, 0, 0), 0, 9'h00B, 2, 0, 2, "R3 len2 seq");
    idle("R2 end len2");
    burst(mk(3'b010, 0, 0), 0, 9'h00D, 4, 0, 4, "R3 len4 seq");
    idle("R2 end len4");
    burst(mk(3'b011, 0, 0), 1, 9'h1FE, 8, 0, 8, "R3 len8 seq wrap");
    idle("R2 end len8");

    // R4 interleave
    burst(mk(3'b011, 1, 0), 0, 9'h005, 8, 1, 8, "R4 len8 ilv");
    idle("R4 end");
    burst(mk(3'b010, 1, 0), 1, 9'h1E6, 4, 1, 4, "R4 len4 ilv");
    idle("R4 end");

    // R5 full page across the 511 -> 0 wrap, then stop (R9)
    burst(mk(3'b111, 0, 0), 0, 9'h1FD, 0, 0, 6, "R5 full page");
    step(mk(3'b111, 0, 0), 0, 0, 9'd0, 1, 0, 9'd0, 0, 0, "R9 stop full page");
    idle("R9 after stop");

    // R7 single-beat write vs full-length read
    burst(mk(3'b010, 0, 1), 1, 9'h020, 1, 0, 1, "R7 single write");
    idle("R7 end write");
    burst(mk(3'b010, 0, 1), 0, 9'h020, 4, 0, 4, "R7 read keeps length");
    idle("R7 end read");

    // R8 interrupt mid-burst
    burst(mk(3'b011, 0, 0), 0, 9'h040, 8, 0, 3, "R8 first burst");
    burst(mk(3'b010, 0, 0), 1, 9'h083, 4, 0, 4, "R8 takeover");
    idle("R8 end");

    // R9 stop mid-burst, then stop and go together
    burst(mk(3'b011, 0, 0), 0, 9'h100, 8, 0, 2, "R9 burst");
    step(mk(3'b011, 0, 0), 0, 0, 9'd0, 1, 0, 9'd0, 0, 0, "R9 stop");
    idle("R9 stays idle");
    step(mk(3'b001, 0, 0), 1, 0, 9'h030, 1, 1, 9'h030, 0, 0, "R9 go beats stop");
    step(mk(3'b001, 0, 0), 0, 0, 9'd0, 0, 1, 9'h031, 1, 0, "R9 go beats stop");
    idle("R9 end");

    // R6 reserved encodings
    step(mk(3'b100, 0, 0), 1, 0, 9'h011, 0, 0, 9'd0, 0, 1, "R6 code100");
    idle("R6 pulse one cycle");
    step(mk(3'b101, 0, 0), 1, 1, 9'h011, 0, 0, 9'd0, 0, 1, "R6 code101");
    step(mk(3'b110, 0, 0), 1, 0, 9'h011, 0, 0, 9'd0, 0, 1, "R6 code110");
    idle("R6 pulse one cycle");
    step(mk(3'b111, 1, 0), 1, 0, 9'h011, 0, 0, 9'd0, 0, 1, "R6 full page ilv");
    idle("R6 no burst");
    burst(mk(3'b010, 0, 0), 0, 9'h050, 4, 0, 2, "R6 burst before error");
    step(mk(3'b110, 0, 0), 1, 0, 9'h060, 0, 0, 9'd0, 0, 1, "R6 error ends burst");
    idle("R6 stays idle");
    idle("R6 stays idle");

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule